// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block decides when a small processor core takes an interrupt and then carries out the entry. A level-sensitive request with a two-bit priority level is looked at only in the cycle in which the execution unit flags the final cycle of the running instruction. A request that arrives while an instruction is under way therefore waits until that instruction ends. Once a request is accepted, the sequencer runs a fixed nine-cycle entry:

- It pushes the program counter and the processor status word to memory through a byte-wide stack-write port.
- It reads a two-byte vector from the address supplied for the pending source.
- It loads that vector into the program counter.
- It writes back the status word with its current-level field set to the accepted level.
- It then signals the first fetch of the service routine.

While the entry runs, the block raises a busy flag so that the execution unit holds. A small meter times each taken request, from the first cycle the request is seen high to the fetch cycle. It reports the latest and the largest measured latency. With a 21-cycle longest instruction the bound is 30 cycles. When only short instructions (at most 6 cycles) are in use, the bound is 15 cycles.

The stack-write port is a valid/ready stream. The sequencer raises `stk_valid` with `stk_addr` and `stk_data`. It holds all three unchanged until a cycle in which `stk_ready` is high, and that cycle completes the transfer. While `stk_ready` stays low the entry pauses in the same push step, so each stalled cycle adds one cycle to the entry. The vector read port has no handshake: `vrd_data` must answer `vrd_addr` within the same cycle. All other pins are plain control and status.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is accepted only in a cycle where `last_cyc` and `irq_req` are both high and no entry is running. A request that rises mid-instruction is first considered at that instruction's last cycle.
- R2: Acceptance further needs the global-enable bit (status bit 3) set, and `irq_lvl` numerically below the current-level field (status bits 5:4). Level 3 is therefore never accepted, and a level equal to the field is not accepted.
- R3: With `stk_ready` high, an entry accepted in cycle A keeps `seq_busy` high in cycles A+1 to A+9, and `isr_fetch` pulses for one cycle in A+10.
- R4: Entry cycles 1 to 4 write, in this order, the PC high byte, the PC low byte, the status high byte and the status low byte. The addresses are SP-1, SP-2, SP-3 and SP-4, using the PC, status and SP values held at acceptance.
- R5: While `stk_valid` is high and `stk_ready` low, valid, address and data hold unchanged, and the entry waits in that push step.
- R6: Entry cycle 5 reads the vector high byte at `vec_addr` and cycle 6 reads the low byte at `vec_addr`+1. Cycle 7 pulses `pc_wr_en` with {high, low}.
- R7: Entry cycle 8 pulses `stat_wr_en` with the saved status whose bits 5:4 are replaced by the accepted level. In the same cycle it pulses `sp_wr_en` with SP-4.
- R8: A request that falls before the instruction's last cycle is never taken.
- R9: A request still high after entry, with the status written back, causes no new entry.
- R10: After a fetch, `lat_last` equals the number of cycles from the first cycle the request was high up to the fetch cycle. This is 30 when the request arrives in the first cycle of a 21-cycle instruction, and 15 for a 6-cycle one.
- R11: `lat_max` holds the largest `lat_last` since reset.
- R12: After reset all strobes, `seq_busy`, `lat_last` and `lat_max` are zero.
- R13: `last_cyc` pulses during a running entry start no second entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 1 | Level interrupt request |
| irq_lvl | input | 2 | Priority level of the pending request (0 highest) |
| last_cyc | input | 1 | High in the final cycle of each instruction |
| cur_pc | input | 16 | Current program counter |
| cur_stat | input | 16 | Current status word (bit 3 enable, bits 5:4 level) |
| cur_sp | input | 16 | Current stack pointer |
| vec_addr | input | 16 | Vector address for the pending source |
| stk_valid | output | 1 | Stack write valid |
| stk_ready | input | 1 | Stack write ready |
| stk_addr | output | 16 | Stack write address |
| stk_data | output | 8 | Stack write byte |
| vrd_en | output | 1 | Vector byte read strobe |
| vrd_addr | output | 16 | Vector byte address |
| vrd_data | input | 8 | Vector byte, same cycle |
| pc_wr_en | output | 1 | Load program counter |
| pc_wr_val | output | 16 | New program counter |
| stat_wr_en | output | 1 | Load status word |
| stat_wr_val | output | 16 | New status word |
| sp_wr_en | output | 1 | Load stack pointer |
| sp_wr_val | output | 16 | New stack pointer |
| seq_busy | output | 1 | Entry in progress, core holds |
| isr_fetch | output | 1 | First fetch cycle of the service routine |
| lat_last | output | 8 | Latency of the latest taken request |
| lat_max | output | 8 | Largest latency since reset |

## Verification
The assertions take for granted that `irq_lvl` stays steady while the request is high. They also assume the core updates its status register from `stat_wr_val` before the next instruction ends, and that `vrd_data` answers the address of the same cycle. The bench models such a core: it rebuilds the status word after each entry, serves vector bytes from a computed memory, and changes `stk_ready` only between clock edges. Requests are raised and dropped only at chosen instruction cycles, so every latency it expects follows from the instruction length and the rise cycle.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  localparam int ENTRY_CYCLES = 9;

  typedef enum logic [3:0] {
    PH_IDLE      = 4'd0,
    PH_PC_HI     = 4'd1,
    PH_PC_LO     = 4'd2,
    PH_ST_HI     = 4'd3,
    PH_ST_LO     = 4'd4,
    PH_VEC_HI    = 4'd5,
    PH_VEC_LO    = 4'd6,
    PH_LOAD_PC   = 4'd7,
    PH_LOAD_ST   = 4'd8,
    PH_HANDOFF   = 4'd9
  } entry_phase_t;

endpackage

// File: rtl/irq_sampler.sv
module irq_sampler #(
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_req,
  input  logic             last_cyc,
  input  logic             glob_en,
  input  logic [LVL_W-1:0] req_lvl,
  input  logic [LVL_W-1:0] run_lvl,
  input  logic             busy,
  output logic             take
);

  logic prio_ok;

  // strictly lower number wins; the all-ones level can never be below anything
  assign prio_ok = (req_lvl < run_lvl);
  assign take    = irq_req & last_cyc & glob_en & prio_ok & ~busy;

  // R1
  sample_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(last_cyc && irq_req));

  // R2
  gate_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(glob_en && (req_lvl < run_lvl)));

  // R3
  take_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy);

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_seq_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int LVL_W   = 2,
  parameter int LVL_LSB = 4,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [LVL_W-1:0]  req_lvl,
  input  logic [WORD_W-1:0] cur_pc,
  input  logic [WORD_W-1:0] cur_stat,
  input  logic [WORD_W-1:0] cur_sp,
  input  logic [WORD_W-1:0] vec_addr,
  input  logic              stk_ready,
  input  logic [BYTE_W-1:0] vrd_data,
  output logic              stk_valid,
  output logic [WORD_W-1:0] stk_addr,
  output logic [BYTE_W-1:0] stk_data,
  output logic              vrd_en,
  output logic [WORD_W-1:0] vrd_addr,
  output logic              pc_wr_en,
  output logic [WORD_W-1:0] pc_wr_val,
  output logic              stat_wr_en,
  output logic [WORD_W-1:0] stat_wr_val,
  output logic              sp_wr_en,
  output logic [WORD_W-1:0] sp_wr_val,
  output logic              busy,
  output logic              isr_fetch
);

  localparam int PH_W = 4;

  entry_phase_t      phase, phase_nxt;
  logic [WORD_W-1:0] pc_q, stat_q, sp_q, vec_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [BYTE_W-1:0] vhi_q, vlo_q;
  logic              fetch_q;
  logic              pushing;

  assign pushing = (phase == PH_PC_HI) || (phase == PH_PC_LO) ||
                   (phase == PH_ST_HI) || (phase == PH_ST_LO);

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_IDLE:    if (take) phase_nxt = PH_PC_HI;
      PH_HANDOFF: phase_nxt = PH_IDLE;
      default: begin
        if (!pushing || stk_ready)
          phase_nxt = entry_phase_t'(phase + 4'd1);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      fetch_q <= 1'b0;
      pc_q    <= '0;
      stat_q  <= '0;
      sp_q    <= '0;
      vec_q   <= '0;
      lvl_q   <= '0;
      vhi_q   <= '0;
      vlo_q   <= '0;
    end else begin
      phase   <= phase_nxt;
      fetch_q <= (phase == PH_HANDOFF);
      if (phase == PH_IDLE && take) begin
        pc_q   <= cur_pc;
        stat_q <= cur_stat;
        sp_q   <= cur_sp;
        vec_q  <= vec_addr;
        lvl_q  <= req_lvl;
      end
      if (phase == PH_VEC_HI) vhi_q <= vrd_data;
      if (phase == PH_VEC_LO) vlo_q <= vrd_data;
    end
  end

  // stack side: the push index equals the phase number 1..4
  assign stk_valid = pushing;
  assign stk_addr  = sp_q - {{(WORD_W-PH_W){1'b0}}, phase};

  always_comb begin
    unique case (phase)
      PH_PC_HI: stk_data = pc_q[WORD_W-1:BYTE_W];
      PH_PC_LO: stk_data = pc_q[BYTE_W-1:0];
      PH_ST_HI: stk_data = stat_q[WORD_W-1:BYTE_W];
      PH_ST_LO: stk_data = stat_q[BYTE_W-1:0];
      default:  stk_data = '0;
    endcase
  end

  // vector side
  assign vrd_en   = (phase == PH_VEC_HI) || (phase == PH_VEC_LO);
  assign vrd_addr = vec_q + {{(WORD_W-1){1'b0}}, (phase == PH_VEC_LO)};

  // register loads
  assign pc_wr_en  = (phase == PH_LOAD_PC);
  assign pc_wr_val = {vhi_q, vlo_q};

  always_comb begin
    stat_wr_val = stat_q;
    stat_wr_val[LVL_LSB +: LVL_W] = lvl_q;
  end
  assign stat_wr_en = (phase == PH_LOAD_ST);
  assign sp_wr_en   = (phase == PH_LOAD_ST);
  assign sp_wr_val  = sp_q - WORD_W'(4);

  assign busy      = (phase != PH_IDLE);
  assign isr_fetch = fetch_q;

  // R5
  stk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_valid && !stk_ready) |=> (stk_valid && $stable(stk_addr) && $stable(stk_data)));

  // R4
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stk_valid, vrd_en, pc_wr_en, stat_wr_en}));

  // R7
  load_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_en |=> (stat_wr_en && sp_wr_en));

  // R3
  handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_en |-> ##2 isr_fetch);

  // R6
  vec_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vrd_en && !$past(vrd_en)) |=> (vrd_en && vrd_addr == $past(vrd_addr) + WORD_W'(1)));

endmodule

// File: rtl/irq_lat_meter.sv
module irq_lat_meter #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_req,
  input  logic             busy,
  input  logic             isr_fetch,
  output logic [LAT_W-1:0] lat_last,
  output logic [LAT_W-1:0] lat_max
);

  localparam logic [LAT_W-1:0] CNT_TOP = '1;

  logic             req_q, running;
  logic [LAT_W-1:0] cnt;
  logic             rise;

  assign rise = irq_req & ~req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      running  <= 1'b0;
      cnt      <= '0;
      lat_last <= '0;
      lat_max  <= '0;
    end else begin
      req_q <= irq_req;
      if (rise && !busy) begin
        running <= 1'b1;
        cnt     <= LAT_W'(1);
      end else if (running) begin
        if (isr_fetch) begin
          running  <= 1'b0;
          lat_last <= cnt;
          if (cnt > lat_max) lat_max <= cnt;
        end else if (!irq_req && !busy) begin
          running <= 1'b0;
        end else if (cnt != CNT_TOP) begin
          cnt <= cnt + LAT_W'(1);
        end
      end
    end
  end

  // R10
  lat_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> running);

  // R11
  max_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(isr_fetch) |-> (lat_max >= lat_last));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int BYTE_W  = 8,
  parameter int LVL_W   = 2,
  parameter int LVL_LSB = 4,
  parameter int EN_BIT  = 3,
  parameter int LAT_W   = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic [LVL_W-1:0]  irq_lvl,
  input  logic              last_cyc,
  input  logic [WORD_W-1:0] cur_pc,
  input  logic [WORD_W-1:0] cur_stat,
  input  logic [WORD_W-1:0] cur_sp,
  input  logic [WORD_W-1:0] vec_addr,
  output logic              stk_valid,
  input  logic              stk_ready,
  output logic [WORD_W-1:0] stk_addr,
  output logic [BYTE_W-1:0] stk_data,
  output logic              vrd_en,
  output logic [WORD_W-1:0] vrd_addr,
  input  logic [BYTE_W-1:0] vrd_data,
  output logic              pc_wr_en,
  output logic [WORD_W-1:0] pc_wr_val,
  output logic              stat_wr_en,
  output logic [WORD_W-1:0] stat_wr_val,
  output logic              sp_wr_en,
  output logic [WORD_W-1:0] sp_wr_val,
  output logic              seq_busy,
  output logic              isr_fetch,
  output logic [LAT_W-1:0]  lat_last,
  output logic [LAT_W-1:0]  lat_max
);

  logic take;

  irq_sampler #(.LVL_W(LVL_W)) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_req  (irq_req),
    .last_cyc (last_cyc),
    .glob_en  (cur_stat[EN_BIT]),
    .req_lvl  (irq_lvl),
    .run_lvl  (cur_stat[LVL_LSB +: LVL_W]),
    .busy     (seq_busy),
    .take     (take)
  );

  irq_entry_fsm #(
    .BYTE_W  (BYTE_W),
    .LVL_W   (LVL_W),
    .LVL_LSB (LVL_LSB)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (take),
    .req_lvl     (irq_lvl),
    .cur_pc      (cur_pc),
    .cur_stat    (cur_stat),
    .cur_sp      (cur_sp),
    .vec_addr    (vec_addr),
    .stk_ready   (stk_ready),
    .vrd_data    (vrd_data),
    .stk_valid   (stk_valid),
    .stk_addr    (stk_addr),
    .stk_data    (stk_data),
    .vrd_en      (vrd_en),
    .vrd_addr    (vrd_addr),
    .pc_wr_en    (pc_wr_en),
    .pc_wr_val   (pc_wr_val),
    .stat_wr_en  (stat_wr_en),
    .stat_wr_val (stat_wr_val),
    .sp_wr_en    (sp_wr_en),
    .sp_wr_val   (sp_wr_val),
    .busy        (seq_busy),
    .isr_fetch   (isr_fetch)
  );

  irq_lat_meter #(.LAT_W(LAT_W)) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .busy      (seq_busy),
    .isr_fetch (isr_fetch),
    .lat_last  (lat_last),
    .lat_max   (lat_max)
  );

endmodule

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;

  localparam int CLK_P = 10;
  localparam int NTBL  = 10;

  // entry: {len[23:16], rise_at[15:8], lvl[7:6], cur_level[5:4], enable[3], taken[2], 2'b0}
  localparam logic [23:0] TBL [NTBL] = '{
    {8'd21, 8'd1,  2'd0, 2'd3, 1'b1, 1'b1, 2'b0},
    {8'd6,  8'd1,  2'd1, 2'd3, 1'b1, 1'b1, 2'b0},
    {8'd3,  8'd2,  2'd2, 2'd3, 1'b1, 1'b1, 2'b0},
    {8'd4,  8'd1,  2'd1, 2'd1, 1'b1, 1'b0, 2'b0},
    {8'd4,  8'd1,  2'd2, 2'd1, 1'b1, 1'b0, 2'b0},
    {8'd4,  8'd1,  2'd3, 2'd3, 1'b1, 1'b0, 2'b0},
    {8'd4,  8'd1,  2'd0, 2'd3, 1'b0, 1'b0, 2'b0},
    {8'd1,  8'd1,  2'd0, 2'd2, 1'b1, 1'b1, 2'b0},
    {8'd21, 8'd21, 2'd1, 2'd2, 1'b1, 1'b1, 2'b0},
    {8'd6,  8'd3,  2'd0, 2'd1, 1'b1, 1'b1, 2'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0;
  logic [1:0]  irq_lvl = 2'd0;
  logic        last_cyc = 1'b0;
  logic [15:0] cur_pc = 16'h1234;
  logic [15:0] cur_stat = 16'h0;
  logic [15:0] cur_sp = 16'h0100;
  logic [15:0] vec_addr = 16'h0080;
  logic        stk_valid, stk_ready = 1'b1;
  logic [15:0] stk_addr;
  logic [7:0]  stk_data;
  logic        vrd_en;
  logic [15:0] vrd_addr;
  logic [7:0]  vrd_data;
  logic        pc_wr_en, stat_wr_en, sp_wr_en, seq_busy, isr_fetch;
  logic [15:0] pc_wr_val, stat_wr_val, sp_wr_val;
  logic [7:0]  lat_last, lat_max;

  int total = 0, fails = 0, cyc = 0, t0 = 0, acc = 0;
  int stk_n, vrd_n, fetch_n, fetch_c, pc_c, st_c;
  logic [15:0] stk_a [8];
  logic [7:0]  stk_d [8];
  int          stk_c [8];
  logic [15:0] vrd_a [2];
  int          vrd_c [2];
  logic [15:0] pc_v, st_v, sp_v;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] vmem(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [15:0] mk_stat(input logic [1:0] lv, input logic en);
    return {8'hC3, 2'b00, lv, en, 3'b101};
  endfunction

  assign vrd_data = vmem(vrd_addr);

  irq_entry_seq i_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_lvl(irq_lvl),
    .last_cyc(last_cyc), .cur_pc(cur_pc), .cur_stat(cur_stat), .cur_sp(cur_sp),
    .vec_addr(vec_addr), .stk_valid(stk_valid), .stk_ready(stk_ready),
    .stk_addr(stk_addr), .stk_data(stk_data), .vrd_en(vrd_en),
    .vrd_addr(vrd_addr), .vrd_data(vrd_data), .pc_wr_en(pc_wr_en),
    .pc_wr_val(pc_wr_val), .stat_wr_en(stat_wr_en), .stat_wr_val(stat_wr_val),
    .sp_wr_en(sp_wr_en), .sp_wr_val(sp_wr_val), .seq_busy(seq_busy),
    .isr_fetch(isr_fetch), .lat_last(lat_last), .lat_max(lat_max)
  );

  // event log, taken at each edge from the values of the ending cycle
  always @(posedge clk) begin
    if (rst_n) begin
      if (stk_valid && stk_ready && stk_n < 8) begin
        stk_a[stk_n] = stk_addr; stk_d[stk_n] = stk_data; stk_c[stk_n] = cyc;
        stk_n = stk_n + 1;
      end
      if (vrd_en && vrd_n < 2) begin
        vrd_a[vrd_n] = vrd_addr; vrd_c[vrd_n] = cyc; vrd_n = vrd_n + 1;
      end
      if (pc_wr_en)   begin pc_v = pc_wr_val; pc_c = cyc; end
      if (stat_wr_en) begin st_v = stat_wr_val; st_c = cyc; end
      if (sp_wr_en)   sp_v = sp_wr_val;
      if (isr_fetch)  begin fetch_n = fetch_n + 1; fetch_c = cyc; end
    end
    cyc = cyc + 1;
  end

  // core model: status and PC registers follow the sequencer's loads
  always @(negedge clk) begin
    if (stat_wr_en) cur_stat = stat_wr_val;
    if (pc_wr_en)   cur_pc   = pc_wr_val;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    stk_n = 0; vrd_n = 0; fetch_n = 0; fetch_c = -1; pc_c = -1; st_c = -1;
    pc_v = '0; st_v = '0; sp_v = '0;
  endtask

  // run one instruction of len cycles; request rises at cycle rise_at, falls at drop_at
  task automatic run_instr(input int len, input int rise_at, input int drop_at);
    for (int c = 1; c <= len; c++) begin
      @(negedge clk);
      if (c == rise_at) begin irq_req = 1'b1; t0 = cyc; end
      if (c == drop_at) irq_req = 1'b0;
      last_cyc = (c == len);
      if (c == len) acc = cyc;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      last_cyc = 1'b0;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    clear_log();
    cur_stat = mk_stat(2'd3, 1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 busy", seq_busy, 0);
    chk("R12 fetch", isr_fetch, 0);
    chk("R12 stk_valid", stk_valid, 0);
    chk("R12 lat_last", lat_last, 0);
    chk("R12 lat_max", lat_max, 0);

    // table of request patterns (R1 R2 R3 R10)
    for (int i = 0; i < NTBL; i++) begin
      int          len, ra;
      logic        tk;
      len = int'(TBL[i][23:16]);
      ra  = int'(TBL[i][15:8]);
      tk  = TBL[i][2];
      clear_log();
      cur_stat = mk_stat(TBL[i][5:4], TBL[i][3]);
      irq_lvl  = TBL[i][7:6];
      run_instr(len, ra, 0);
      idle(12);
      chk($sformatf("R2 taken entry %0d", i), fetch_n, tk ? 1 : 0);
      if (tk) begin
        chk($sformatf("R3 fetch cycle entry %0d", i), fetch_c, acc + 10);
        chk($sformatf("R10 latency entry %0d", i), lat_last, len + 10 - ra);
      end
      irq_req = 1'b0;
      idle(2);
    end
    // R11 largest so far is the 21-cycle case
    chk("R11 lat_max", lat_max, 30);

    // detailed entry: R4 R6 R7
    clear_log();
    cur_pc = 16'h1234; cur_sp = 16'h0100; vec_addr = 16'h0080;
    cur_stat = mk_stat(2'd3, 1'b1); irq_lvl = 2'd1;
    run_instr(2, 1, 0);
    idle(12);
    chk("R4 push count", stk_n, 4);
    chk("R4 push0", {stk_a[0], stk_d[0]}, {16'h00FF, 8'h12});
    chk("R4 push1", {stk_a[1], stk_d[1]}, {16'h00FE, 8'h34});
    chk("R4 push2", {stk_a[2], stk_d[2]}, {16'h00FD, 8'hC3});
    chk("R4 push3", {stk_a[3], stk_d[3]}, {16'h00FC, 8'h3D});
    chk("R4 push cycles", stk_c[0] == acc + 1 && stk_c[3] == acc + 4, 1);
    chk("R6 vec addrs", {vrd_a[0], vrd_a[1]}, {16'h0080, 16'h0081});
    chk("R6 vec cycles", vrd_c[0] == acc + 5 && vrd_c[1] == acc + 6, 1);
    chk("R6 pc load", pc_v, {vmem(16'h0080), vmem(16'h0081)});
    chk("R6 pc cycle", pc_c, acc + 7);
    chk("R7 stat load", st_v, mk_stat(2'd1, 1'b1));
    chk("R7 stat cycle", st_c, acc + 8);
    chk("R7 sp load", sp_v, 16'h00FC);

    // R9 request held high after entry is masked
    clear_log();
    run_instr(3, 0, 0);
    idle(12);
    chk("R9 no reentry", fetch_n, 0);
    chk("R9 no pushes", stk_n, 0);
    irq_req = 1'b0;
    idle(2);

    // R13 last-cycle strobes during a running entry
    clear_log();
    cur_stat = mk_stat(2'd3, 1'b1); irq_lvl = 2'd0;
    run_instr(2, 1, 0);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      last_cyc = 1'b1;
    end
    idle(12);
    chk("R13 single entry", fetch_n, 1);
    chk("R13 four pushes", stk_n, 4);
    irq_req = 1'b0;
    idle(2);

    // R8 request withdrawn before the last cycle
    clear_log();
    cur_stat = mk_stat(2'd3, 1'b1); irq_lvl = 2'd0;
    run_instr(5, 1, 3);
    idle(12);
    chk("R8 not taken", fetch_n, 0);
    chk("R8 no pushes", stk_n, 0);

    // R5 back-pressure on the second push
    clear_log();
    cur_pc = 16'hABCD; cur_sp = 16'h0200;
    cur_stat = mk_stat(2'd3, 1'b1); irq_lvl = 2'd2;
    run_instr(2, 1, 0);
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      last_cyc  = 1'b0;
      stk_ready = !(k >= 2 && k <= 4);
    end
    chk("R5 pushes after stall", {stk_a[1], stk_d[1], stk_a[3]}, {16'h01FE, 8'hCD, 16'h01FC});
    chk("R5 second push cycle", stk_c[1], acc + 5);
    chk("R5 fetch delayed", fetch_c, acc + 13);
    irq_req = 1'b0;
    idle(2);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule